// File: doc/BRIEF.md
# Video Processor Host Port

This block is the port through which a host CPU talks to a tile-based video display processor. The host builds a command from two control-port writes. Together the two writes set a 16-bit memory address and a 6-bit access code. The host then streams 16-bit words through the data port. Each accepted word is queued in a four-entry write queue, tagged with the access code that was current when it arrived. After each accepted word the address advances by a programmable step. A control-port read returns a status word that reports queue fill, DMA activity and vertical blanking.

The back end removes the oldest queued word with a one-cycle drain strobe. A DMA engine outside the block raises a running flag. While that flag is high, every host write is refused with `busy` and has no effect. A data write also stalls with `busy` while the queue is full. The host must hold a refused request until `busy` falls, and the request is taken at the first clock edge at which `busy` is low.

The command latch is a two-state machine. CMD_IDLE moves to CMD_HALF on an accepted control write (transition FIRST_WORD). CMD_HALF moves back to CMD_IDLE on a second accepted control write (transition SECOND_WORD). CMD_HALF also moves back to CMD_IDLE on a control read or an accepted data write (transition CANCEL). The output `pending` is high in CMD_HALF. When requests coincide, the control write wins over the data write, and the data write wins over the control read.

Top module: `vdp_host_port`

## Requirements
- R1: While `dma_running` is high, control and data writes raise `busy`, and `addr`, `code`, `pending` and the queue stay unchanged.
- R2: A control write taken with `pending` low loads addr[13:0] from data[13:0] and code[1:0] from data[15:14]. It keeps addr[15:14] and code[5:2], and sets `pending`.
- R3: A control write taken with `pending` high loads addr[15:14] from data[1:0] and code[5:2] from data[7:4]. It keeps addr[13:0] and code[1:0], and clears `pending`.
- R4: A data write while code[0] is 0 (a read code) is dropped. It does not raise `busy`, pushes nothing, and leaves `addr` and `pending` unchanged.
- R5: An accepted data write (code[0] is 1) pushes {data, code, partial=0} into the queue and clears `pending`.
- R6: A data write while the queue holds four entries raises `busy` and changes nothing. It is taken in the first cycle after a drain frees an entry.
- R7: After each accepted data write, `addr` advances by `autoinc`, modulo 2^16.
- R8: A control read (`ctrl_rd`) clears `pending` and leaves `addr` and `code` unchanged.
- R9: `status` bit 9 is high when the queue is empty, bit 8 when it is full, and bit 1 while `dma_running` is high. Bit 3 is high when `line_num` is at least 240 (`pal_mode`=1) or at least 224 (`pal_mode`=0). All other bits read 0.
- R10: A `drain` strobe removes the oldest entry, so entries leave in arrival order. A drain of an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control-port write request |
| data_wr | input | 1 | Data-port write request |
| ctrl_rd | input | 1 | Control-port read (status read) |
| wr_data | input | 16 | Write value for either port |
| autoinc | input | 8 | Address step applied after each accepted data write |
| dma_running | input | 1 | DMA engine busy flag |
| line_num | input | 9 | Current scan line |
| pal_mode | input | 1 | Latched 50 Hz mode, selects active line count |
| drain | input | 1 | Back end pops the oldest queue entry |
| busy | output | 1 | Current request refused, hold it |
| status | output | 16 | Status word |
| addr | output | 16 | Current memory address |
| code | output | 6 | Current access code |
| pending | output | 1 | First command word received |
| head_valid | output | 1 | Queue not empty |
| head_data | output | 16 | Oldest queued value |
| head_code | output | 6 | Access code of oldest entry |
| head_partial | output | 1 | Partial flag of oldest entry |

## Verification
The hardest case to reach is a data write that is stalled on a full queue and is then taken in the cycle right after a drain. To get there, the stimulus fills the queue with four accepted writes. It then holds a fifth write for several cycles while checking that `busy` stays high and `addr` stays put. Next it pulses `drain` with the request still held, and confirms that the held word is taken at the following edge and comes out last. The boundary lines 223/224 and 239/240 are applied in both video modes to check the blanking bit.

// File: rtl/vdp_hp_pkg.sv
package vdp_hp_pkg;
    localparam int ADDR_W = 16;
    localparam int CODE_W = 6;
    localparam int DATA_W = 16;

    typedef enum logic {
        CMD_IDLE = 1'b0,
        CMD_HALF = 1'b1
    } cmd_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CODE_W-1:0] code;
        logic              partial;
    } wq_entry_t;
endpackage

// File: rtl/hp_cmd_fsm.sv
module hp_cmd_fsm
    import vdp_hp_pkg::*;
#(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_acc,
    input  logic              data_acc,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CODE_W-1:0] code_q,
    output logic              pending
);
    localparam int HI_ADDR = ADDR_W - 14;
    localparam int HI_CODE = CODE_W - 2;

    cmd_state_t state_q, state_d;
    logic [ADDR_W-1:0] addr_d;
    logic [CODE_W-1:0] code_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CMD_IDLE;
            addr_q  <= '0;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            code_q  <= code_d;
        end
    end

    // next state and latch contents
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        code_d  = code_q;
        unique case (state_q)
            CMD_IDLE: begin
                if (ctrl_acc) begin
                    // FIRST_WORD
                    addr_d = {addr_q[ADDR_W-1:14], wr_val[13:0]};
                    code_d = {code_q[CODE_W-1:2], wr_val[15:14]};
                    state_d = CMD_HALF;
                end else if (data_acc) begin
                    addr_d = addr_q + ADDR_W'(step);
                end
            end
            CMD_HALF: begin
                if (ctrl_acc) begin
                    // SECOND_WORD
                    addr_d = {wr_val[HI_ADDR-1:0], addr_q[13:0]};
                    code_d = {wr_val[4 +: HI_CODE], code_q[1:0]};
                    state_d = CMD_IDLE;
                end else if (data_acc) begin
                    // CANCEL by data write
                    addr_d = addr_q + ADDR_W'(step);
                    state_d = CMD_IDLE;
                end else if (rd_req) begin
                    // CANCEL by status read
                    state_d = CMD_IDLE;
                end
            end
            default: state_d = CMD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pending = (state_q == CMD_HALF);
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !ctrl_acc) |=> (addr_q == $past(addr_q) + ADDR_W'($past(step)))); // R7
    AST_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_acc && pending) |=> (!pending && addr_q[13:0] == $past(addr_q[13:0]) && code_q[1:0] == $past(code_q[1:0]))); // R3
    AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_acc && !pending) |=> (pending && addr_q[ADDR_W-1:14] == $past(addr_q[ADDR_W-1:14]))); // R2
    AST_RD_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !ctrl_acc && !data_acc) |=> (!pending && $stable(addr_q) && $stable(code_q))); // R8
endmodule

// File: rtl/hp_wr_queue.sv
module hp_wr_queue
    import vdp_hp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  wq_entry_t push_ent,
    input  logic      pop,
    output wq_entry_t head,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    wq_entry_t          slots [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   count;
    logic               do_pop;

    assign do_pop = pop && !empty;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[i] <= '0;
            end else if (push && wr_ptr == PTR_W'(i)) begin
                slots[i] <= push_ent;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CNT_W'(push) - CNT_W'(do_pop);
        end
    end

    always_comb begin
        empty = (count == '0);
        full  = (count == CNT_W'(DEPTH));
        head  = slots[rd_ptr];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R6
    AST_EMPTY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty); // R10
endmodule

// File: rtl/hp_status.sv
module hp_status #(
    parameter int LINE_W     = 9,
    parameter int PAL_LINES  = 240,
    parameter int NTSC_LINES = 224
) (
    input  logic              q_empty,
    input  logic              q_full,
    input  logic              dma_on,
    input  logic [LINE_W-1:0] line,
    input  logic              pal,
    output logic [15:0]       word
);
    localparam logic [LINE_W-1:0] PAL_LIM  = LINE_W'(PAL_LINES);
    localparam logic [LINE_W-1:0] NTSC_LIM = LINE_W'(NTSC_LINES);

    logic blank;

    always_comb begin
        blank = (line >= (pal ? PAL_LIM : NTSC_LIM));
        word      = '0;
        word[9]   = q_empty;
        word[8]   = q_full;
        word[3]   = blank;
        word[1]   = dma_on;
    end
endmodule

// File: rtl/vdp_host_port.sv
module vdp_host_port
    import vdp_hp_pkg::*;
#(
    parameter int Q_DEPTH    = 4,
    parameter int STEP_W     = 8,
    parameter int LINE_W     = 9,
    parameter int PAL_LINES  = 240,
    parameter int NTSC_LINES = 224
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              data_wr,
    input  logic              ctrl_rd,
    input  logic [15:0]       wr_data,
    input  logic [STEP_W-1:0] autoinc,
    input  logic              dma_running,
    input  logic [LINE_W-1:0] line_num,
    input  logic              pal_mode,
    input  logic              drain,
    output logic              busy,
    output logic [15:0]       status,
    output logic [15:0]       addr,
    output logic [5:0]        code,
    output logic              pending,
    output logic              head_valid,
    output logic [15:0]       head_data,
    output logic [5:0]        head_code,
    output logic              head_partial
);
    logic      ctrl_acc, data_acc, q_empty, q_full, wr_mode;
    wq_entry_t new_ent, head;

    always_comb begin
        wr_mode  = code[0];
        ctrl_acc = ctrl_wr && !dma_running;
        data_acc = data_wr && !ctrl_wr && !dma_running && wr_mode && !q_full;
        busy     = (dma_running && (ctrl_wr || data_wr))
                 || (data_wr && !ctrl_wr && wr_mode && q_full);
        new_ent.data    = wr_data;
        new_ent.code    = code;
        new_ent.partial = 1'b0;
    end

    hp_cmd_fsm #(.STEP_W(STEP_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_acc(ctrl_acc),
        .data_acc(data_acc),
        .rd_req  (ctrl_rd),
        .wr_val  (wr_data),
        .step    (autoinc),
        .addr_q  (addr),
        .code_q  (code),
        .pending (pending)
    );

    hp_wr_queue #(.DEPTH(Q_DEPTH)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (data_acc),
        .push_ent(new_ent),
        .pop     (drain),
        .head    (head),
        .empty   (q_empty),
        .full    (q_full)
    );

    hp_status #(
        .LINE_W    (LINE_W),
        .PAL_LINES (PAL_LINES),
        .NTSC_LINES(NTSC_LINES)
    ) u_status (
        .q_empty(q_empty),
        .q_full (q_full),
        .dma_on (dma_running),
        .line   (line_num),
        .pal    (pal_mode),
        .word   (status)
    );

    always_comb begin
        head_valid   = !q_empty;
        head_data    = head.data;
        head_code    = head.code;
        head_partial = head.partial;
    end

    AST_DMA_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_running |=> ($stable(addr) && $stable(code))); // R1
    AST_READ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !ctrl_wr && !ctrl_rd && !code[0]) |=> ($stable(addr) && $stable(pending))); // R4
    AST_PUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !busy && code[0] && !ctrl_wr) |=> !pending); // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ctrl_wr && !dma_running) |=> $stable(addr)); // R6
endmodule

// File: tb/test_vdp_host_port.sv
`timescale 1ns/1ps
module test_vdp_host_port;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        ctrl_wr = 0, data_wr = 0, ctrl_rd = 0, drain = 0;
    logic [15:0] wr_data = 0;
    logic [7:0]  autoinc = 0;
    logic        dma_running = 0, pal_mode = 0;
    logic [8:0]  line_num = 0;
    logic        busy, pending, head_valid, head_partial;
    logic [15:0] status, addr, head_data;
    logic [5:0]  code, head_code;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    vdp_host_port i_vdp_host_port (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .data_wr(data_wr),
        .ctrl_rd(ctrl_rd), .wr_data(wr_data), .autoinc(autoinc),
        .dma_running(dma_running), .line_num(line_num), .pal_mode(pal_mode),
        .drain(drain), .busy(busy), .status(status), .addr(addr), .code(code),
        .pending(pending), .head_valid(head_valid), .head_data(head_data),
        .head_code(head_code), .head_partial(head_partial)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ctrl_write(input logic [15:0] v);
        @(negedge clk);
        ctrl_wr = 1; wr_data = v;
        #1;
        while (busy) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        ctrl_wr = 0;
    endtask

    task automatic data_write(input logic [15:0] v);
        @(negedge clk);
        data_wr = 1; wr_data = v;
        #1;
        while (busy) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        data_wr = 0;
    endtask

    task automatic pulse_drain();
        @(negedge clk);
        drain = 1;
        @(posedge clk); #1;
        drain = 0;
    endtask

    task automatic t_reset();
        chk("R9 reset status", status, 16'h0200);
        chk("R2 reset addr", addr, 0);
        chk("R2 reset code", code, 0);
        chk("R8 reset pending", pending, 0);
        chk("R1 reset busy", busy, 0);
    endtask

    task automatic t_command();
        ctrl_write(16'h4123);
        chk("R2 first addr", addr, 16'h0123);
        chk("R2 first code", code, 6'h01);
        chk("R2 pending set", pending, 1);
        ctrl_write(16'h0092);
        chk("R3 second addr", addr, 16'h8123);
        chk("R3 second code", code, 6'h25);
        chk("R3 pending clear", pending, 0);
        ctrl_write(16'h7FFF);
        chk("R2 keeps high addr", addr, 16'hBFFF);
        chk("R2 keeps high code", code, 6'h25);
        @(negedge clk); ctrl_rd = 1;
        @(posedge clk); #1; ctrl_rd = 0;
        chk("R8 read clears pending", pending, 0);
        chk("R8 read keeps addr", addr, 16'hBFFF);
    endtask

    task automatic t_read_mode();
        ctrl_write(16'h0010);
        chk("R4 setup code", code, 6'h24);
        @(negedge clk); data_wr = 1; wr_data = 16'hDEAD; #1;
        chk("R4 no busy", busy, 0);
        @(posedge clk); #1; data_wr = 0;
        chk("R4 addr kept", addr, 16'hBFD0 & 16'hC010 | 16'h0010);
        chk("R4 pending kept", pending, 1);
        chk("R4 no push", head_valid, 0);
        ctrl_write(16'h0000);
        chk("R3 addr low", addr, 16'h0010);
        chk("R3 code zero", code, 6'h00);
    endtask

    task automatic t_queue_stall();
        autoinc = 8'd2;
        ctrl_write(16'h4000);
        chk("R2 write code", code, 6'h01);
        data_write(16'h1111);
        chk("R5 pending cleared", pending, 0);
        chk("R7 addr step", addr, 16'h0002);
        chk("R5 head data", head_data, 16'h1111);
        chk("R5 head code", head_code, 6'h01);
        chk("R5 head partial", head_partial, 0);
        data_write(16'h2222);
        data_write(16'h3333);
        data_write(16'h4444);
        chk("R9 full status", status, 16'h0100);
        chk("R7 addr after four", addr, 16'h0008);
        @(negedge clk); data_wr = 1; wr_data = 16'hAAAA; #1;
        chk("R6 busy on full", busy, 1);
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R6 addr held", addr, 16'h0008);
        chk("R6 still busy", busy, 1);
        drain = 1;
        @(posedge clk); #1;
        drain = 0;
        chk("R10 oldest popped", head_data, 16'h2222);
        chk("R6 busy released", busy, 0);
        @(posedge clk); #1;
        data_wr = 0;
        chk("R6 held write taken", addr, 16'h000A);
        chk("R9 full again", status[8], 1);
        chk("R10 order 2", head_data, 16'h2222);
        pulse_drain();
        chk("R10 order 3", head_data, 16'h3333);
        pulse_drain();
        chk("R10 order 4", head_data, 16'h4444);
        pulse_drain();
        chk("R10 order 5", head_data, 16'hAAAA);
        chk("R5 tag kept", head_code, 6'h01);
        pulse_drain();
        chk("R10 empty", head_valid, 0);
        pulse_drain();
        chk("R10 empty drain", status, 16'h0200);
    endtask

    task automatic t_wrap();
        autoinc = 8'h80;
        ctrl_write(16'h7FC0);
        ctrl_write(16'h0003);
        chk("R3 wrap setup", addr, 16'hFFC0);
        data_write(16'h5A5A);
        chk("R7 wrap", addr, 16'h0040);
        pulse_drain();
    endtask

    task automatic t_dma();
        logic [15:0] a0;
        logic        p0;
        ctrl_write(16'h4100);
        a0 = addr; p0 = pending;
        dma_running = 1;
        #1;
        chk("R9 dma bit", status, 16'h0202);
        @(negedge clk); ctrl_wr = 1; wr_data = 16'h00F3; #1;
        chk("R1 ctrl busy", busy, 1);
        @(posedge clk); #1; ctrl_wr = 0;
        chk("R1 addr frozen", addr, a0);
        chk("R1 pending frozen", pending, p0);
        @(negedge clk); data_wr = 1; wr_data = 16'h7777; #1;
        chk("R1 data busy", busy, 1);
        @(posedge clk); #1; data_wr = 0;
        chk("R1 no push", head_valid, 0);
        chk("R1 addr frozen 2", addr, a0);
        dma_running = 0;
        ctrl_write(16'h0000);
    endtask

    task automatic t_blank();
        line_num = 9'd223; pal_mode = 0; #1;
        chk("R9 ntsc 223", status[3], 0);
        line_num = 9'd224; #1;
        chk("R9 ntsc 224", status, 16'h0208);
        pal_mode = 1; #1;
        chk("R9 pal 224", status[3], 0);
        line_num = 9'd239; #1;
        chk("R9 pal 239", status[3], 0);
        line_num = 9'd240; #1;
        chk("R9 pal 240", status[3], 1);
        line_num = 0; pal_mode = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        t_reset();
        t_command();
        t_read_mode();
        t_queue_stall();
        t_wrap();
        t_dma();
        t_blank();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule